// File: doc/BRIEF.md
# Dual-Threshold Period Watchdog

A watchdog timer with a counter that advances once per tick strobe. The tick normally comes from a slow clock divided by 128. Three programmable limits sit against that counter. The period limit marks a timeout and wraps the counter back to zero. The repeat limit catches a refresh that comes too early, before the counter has climbed to it. The level limit gives an early-warning interrupt. Each limit has its own status flag. Firmware arms interrupts through separate set and clear mask registers. A one-clock reset request can be tied independently to a period timeout or to an early refresh.

Software reaches the block through a simple synchronous register bus. A keyed write to the control register refreshes the counter. The live counter can be read back. Counting can be frozen while a debug or idle input is high, when the mode register asks for it.

Top module: `dual_threshold_wdt`

## Requirements
- R1: After reset the block reads back as follows. The counter at 0x08 is 0. The mode register at 0x04 is 0x0000_1000, which means the watchdog is stopped. The window register at 0x0C is 0x0000_0FFF: period all ones in bits 11:0 and repeat limit 0 in bits 27:16. The level register at 0x10 is 0x0000_0FFF. Mask (0x20) and status (0x1C) are 0, and both outputs are low.
- R2: While mode bit 12 is 0, each tick raises the counter (bits 11:0 of 0x08) by one. While bit 12 is 1, the counter is held at zero.
- R3: When a tick brings the counter to the period value, status bit 0 is set and the counter returns to 0 on that tick.
- R4: When a tick brings the counter to the level value, status bit 2 is set and counting carries on.
- R5: A write to 0x00 with 0xA5 in bits 31:24 and bit 0 set clears the counter. A write to 0x00 with any other key leaves the counter unchanged.
- R6: A refresh while the counter is below the repeat limit sets status bit 1. A refresh at or above the limit sets no flag.
- R7: The reset output goes high for exactly one clock after a period event when mode bit 4 is set, or after an early refresh when mode bit 5 is set. It stays low for either event when its bit is clear.
- R8: With mode bit 28 set and the debug input high, ticks are ignored. With mode bit 29 set and the idle input high, ticks are ignored. A halt input has no effect when its mode bit is clear.
- R9: Writing ones to 0x14 sets mask bits. Writing ones to 0x18 clears mask bits. 0x20 reads the mask. The interrupt output is high while any status bit has its mask bit set.
- R10: Reading 0x1C returns the status bits (bit 0 period, bit 1 early, bit 2 level) and clears them. An event that occurs in the same cycle as the read survives the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on 0x1C) |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tick_i | input | 1 | Counting strobe, one clock wide |
| dbg_i | input | 1 | Debug state |
| idle_i | input | 1 | Idle state |
| wdt_rst_o | output | 1 | One-clock reset request |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 12-bit counter and the 0xA5 refresh key. It drives a tick on every clock during a stretch. That puts the full 4095-tick period within a few thousand cycles, so the top of the counter range and the wrap to zero are both exercised. Small programmed limits exercise the level flag firing below the period, early and on-time refreshes on either side of the repeat limit, and the case where a tick and a status read fall in the same cycle.

// File: rtl/dual_threshold_wdt.sv
module dual_threshold_wdt #(
  parameter int CNT_W = 12,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_i,
  input  logic        dbg_i,
  input  logic        idle_i,
  output logic        wdt_rst_o,
  output logic        irq_o
);
  localparam logic [5:0] A_CTL = 6'h00, A_MODE = 6'h04, A_CNT = 6'h08, A_WIN = 6'h0C,
                         A_LVL = 6'h10, A_MSET = 6'h14, A_MCLR = 6'h18, A_STAT = 6'h1C,
                         A_MASK = 6'h20;
  localparam int B_PRST = 4, B_ERST = 5, B_OFF = 12, B_HDBG = 28, B_HIDL = 29;
  localparam logic [31:0] MODE_BITS = (32'd1 << B_PRST) | (32'd1 << B_ERST) |
                                      (32'd1 << B_OFF) | (32'd1 << B_HDBG) | (32'd1 << B_HIDL);
  localparam int THR_LSB = 16;

  logic [CNT_W-1:0] cnt_q, period_q, thr_q, level_q;
  logic [31:0] mode_q;
  logic [2:0]  status_q, mask_q, set_ev;

  wire wr_ctl  = bus_wr && bus_addr == A_CTL;
  wire refresh = wr_ctl && bus_wdata[31:24] == KEY && bus_wdata[0];
  wire off     = mode_q[B_OFF];
  wire run     = !off && !(mode_q[B_HDBG] && dbg_i) && !(mode_q[B_HIDL] && idle_i);
  wire step    = run && tick_i && !refresh;
  wire [CNT_W-1:0] cnt_inc = cnt_q + 1'b1;
  wire hit_prd   = step && cnt_inc == period_q;
  wire hit_lvl   = step && cnt_inc == level_q;
  wire hit_early = refresh && !off && cnt_q < thr_q;
  wire rd_stat   = bus_rd && bus_addr == A_STAT;

  assign set_ev = {hit_lvl, hit_early, hit_prd};
  assign irq_o  = |(status_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      mode_q    <= 32'd1 << B_OFF;
      period_q  <= '1;
      thr_q     <= '0;
      level_q   <= '1;
      status_q  <= '0;
      mask_q    <= '0;
      wdt_rst_o <= 1'b0;
    end else begin
      if (off || refresh || hit_prd) cnt_q <= '0;
      else if (step) cnt_q <= cnt_inc;
      if (bus_wr) begin
        case (bus_addr)
          A_MODE: mode_q <= bus_wdata & MODE_BITS;
          A_WIN: begin
            period_q <= bus_wdata[CNT_W-1:0];
            thr_q    <= bus_wdata[THR_LSB +: CNT_W];
          end
          A_LVL:  level_q <= bus_wdata[CNT_W-1:0];
          A_MSET: mask_q  <= mask_q | bus_wdata[2:0];
          A_MCLR: mask_q  <= mask_q & ~bus_wdata[2:0];
          default: ;
        endcase
      end
      status_q  <= (rd_stat ? 3'b000 : status_q) | set_ev;
      wdt_rst_o <= (hit_prd && mode_q[B_PRST]) || (hit_early && mode_q[B_ERST]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE: bus_rdata = mode_q;
      A_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
      A_WIN: begin
        bus_rdata[CNT_W-1:0] = period_q;
        bus_rdata[THR_LSB +: CNT_W] = thr_q;
      end
      A_LVL:  bus_rdata[CNT_W-1:0] = level_q;
      A_STAT: bus_rdata[2:0] = status_q;
      A_MASK: bus_rdata[2:0] = mask_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/dual_threshold_wdt_chk.sv
module dual_threshold_wdt_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [31:0]      mode_q,
  input logic [2:0]       status_q,
  input logic             dbg_i,
  input logic             refresh,
  input logic             wdt_rst_o,
  input logic             irq_o
);
  AST_STEP_OR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == '0 || cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[12] |=> cnt_q == '0); // R2
  AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[28] && dbg_i && !refresh && !mode_q[12]) |=> $stable(cnt_q)); // R8
  AST_RESET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> |status_q[1:0]); // R7
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |status_q); // R9
endmodule

bind dual_threshold_wdt dual_threshold_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .mode_q(mode_q), .status_q(status_q),
  .dbg_i(dbg_i), .refresh(refresh), .wdt_rst_o(wdt_rst_o), .irq_o(irq_o)
);

// File: tb/dual_threshold_wdt_tb.sv
`timescale 1ns/1ps
module dual_threshold_wdt_tb;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tick_i = 0, dbg_i = 0, idle_i = 0;
  logic wdt_rst_o, irq_o;
  int checks = 0, errors = 0, rst_cnt = 0;

  always #5 clk = ~clk;
  always @(negedge clk) if (wdt_rst_o) rst_cnt++;

  dual_threshold_wdt u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_i = 1;
    repeat (n) @(negedge clk);
    tick_i = 0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    chk("R1 rst_o", {31'd0, wdt_rst_o}, 0);
    chk("R1 irq_o", {31'd0, irq_o}, 0);
    rd_chk("R1 mode", 6'h04, 32'h0000_1000);
    rd_chk("R1 counter", 6'h08, 0);
    rd_chk("R1 window", 6'h0C, 32'h0000_0FFF);
    rd_chk("R1 level", 6'h10, 32'h0000_0FFF);
    rd_chk("R1 mask", 6'h20, 0);
    rd_chk("R1 status", 6'h1C, 0);
  endtask

  task automatic t_count();
    ticks(5);
    rd_chk("R2 stopped", 6'h08, 0);
    wr(6'h04, 0);
    ticks(5);
    rd_chk("R2 counting", 6'h08, 5);
  endtask

  task automatic t_refresh();
    wr(6'h00, 32'h5A00_0001);
    rd_chk("R5 bad key", 6'h08, 5);
    wr(6'h00, 32'hA500_0001);
    rd_chk("R5 good key", 6'h08, 0);
  endtask

  task automatic t_period();
    wr(6'h0C, 10);
    wr(6'h04, 32'h10);
    rst_cnt = 0;
    ticks(9);
    rd_chk("R3 below period", 6'h08, 9);
    chk("R7 no early pulse", rst_cnt, 0);
    ticks(1);
    @(negedge clk);
    chk("R7 one pulse", rst_cnt, 1);
    rd_chk("R3 wrapped", 6'h08, 0);
    rd_chk("R3 flag", 6'h1C, 1);
    rd_chk("R10 cleared", 6'h1C, 0);
  endtask

  task automatic t_level();
    wr(6'h04, 0);
    wr(6'h10, 4);
    rst_cnt = 0;
    ticks(4);
    rd_chk("R4 count", 6'h08, 4);
    ticks(2);
    rd_chk("R4 continues", 6'h08, 6);
    rd_chk("R4 flag", 6'h1C, 4);
    chk("R7 level no reset", rst_cnt, 0);
  endtask

  task automatic t_early();
    wr(6'h10, 0);
    wr(6'h0C, (8 << 16) | 20);
    rst_cnt = 0;
    wr(6'h00, 32'hA500_0001);
    @(negedge clk);
    chk("R7 gated off", rst_cnt, 0);
    rd_chk("R6 early flag", 6'h1C, 2);
    wr(6'h04, 32'h20);
    ticks(3);
    wr(6'h00, 32'hA500_0001);
    @(negedge clk);
    chk("R7 early pulse", rst_cnt, 1);
    rd_chk("R6 early again", 6'h1C, 2);
    ticks(9);
    wr(6'h00, 32'hA500_0001);
    rd_chk("R6 on time", 6'h1C, 0);
    rd_chk("R5 cleared", 6'h08, 0);
  endtask

  task automatic t_mask();
    wr(6'h04, 0);
    wr(6'h14, 7);
    rd_chk("R9 mask set", 6'h20, 7);
    wr(6'h18, 2);
    rd_chk("R9 mask clr", 6'h20, 5);
    ticks(2);
    wr(6'h00, 32'hA500_0001);
    chk("R9 masked", {31'd0, irq_o}, 0);
    wr(6'h14, 2);
    chk("R9 irq on", {31'd0, irq_o}, 1);
    rd_chk("R10 read", 6'h1C, 2);
    chk("R10 irq drops", {31'd0, irq_o}, 0);
  endtask

  task automatic t_halt();
    wr(6'h0C, 20);
    wr(6'h04, 32'h1000_0000);
    wr(6'h00, 32'hA500_0001);
    dbg_i = 1;
    ticks(3);
    rd_chk("R8 debug halt", 6'h08, 0);
    dbg_i = 0;
    ticks(3);
    rd_chk("R8 debug off", 6'h08, 3);
    wr(6'h04, 32'h2000_0000);
    idle_i = 1;
    ticks(3);
    rd_chk("R8 idle halt", 6'h08, 3);
    idle_i = 0; dbg_i = 1;
    ticks(2);
    rd_chk("R8 debug not armed", 6'h08, 5);
    dbg_i = 0;
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(6'h04, 0);
    wr(6'h0C, 3);
    wr(6'h00, 32'hA500_0001);
    ticks(2);
    @(negedge clk); tick_i = 1; bus_rd = 1; bus_addr = 6'h1C; #1 d = bus_rdata;
    @(negedge clk); tick_i = 0; bus_rd = 0;
    chk("R10 read before", d, 0);
    rd_chk("R10 event kept", 6'h1C, 1);
  endtask

  task automatic t_full();
    wr(6'h0C, 32'hFFF);
    wr(6'h00, 32'hA500_0001);
    ticks(4094);
    rd_chk("R3 top", 6'h08, 32'hFFE);
    rd_chk("R3 no flag yet", 6'h1C, 0);
    ticks(1);
    rd_chk("R3 full wrap", 6'h08, 0);
    rd_chk("R3 full flag", 6'h1C, 1);
    ticks(3);
    wr(6'h04, 32'h1000);
    rd_chk("R2 stop clears", 6'h08, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_count();
    t_refresh();
    t_period();
    t_level();
    t_early();
    t_mask();
    t_halt();
    t_race();
    t_full();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule